// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler

This block sits inside a behavioural model of a byte-wide flash device. A command decoder upstream hands it single-cycle strobes: add a sector to the erase set, erase the whole chip, suspend, resume, or "some other command". The scheduler gathers sector selections in an 8-bit mask. The mask covers eight 64 KB sectors, and the sector number is the top three address bits. Each accepted selection restarts an acceptance window timed in clock cycles. When the window runs out with no new selection, the block works through the selected sectors one at a time, in ascending sector order.

For each sector, the block first writes zero to every location, one write strobe per location. It then issues a single erase strobe for the whole sector. Sectors flagged as protected are dropped silently. A chip-erase strobe skips the window and starts on every unprotected sector at once. While the erase runs, a suspend strobe freezes all progress. During that pause the read path may use any sector that is not still pending. A resume strobe continues from the exact point where the work stopped. Real cell behaviour and voltage generation are outside this block. Every duration is a parameter in clock cycles.

Top module: `erase_sched`

## Requirements
- R1: An add strobe while the block is idle sets mask bit `add_sel_i` (bit n is sector n) and raises `window_o` for exactly WIN_CYC cycles, counted from the clock edge that samples the strobe.
- R2: An add strobe while `window_o` is high ORs its sector into the mask and restarts the full WIN_CYC count from the edge that samples it.
- R3: While `window_o` is high, an other-command, chip-erase or resume strobe empties the mask, and `window_o` is low in the next cycle with no array activity. A suspend strobe in the window has no effect on it.
- R4: When the window expires, the first zero-write strobe appears in the cycle right after `window_o` falls. Sectors are visited in ascending order. Each sector gets 2^OFS_W `arr_prog_o` strobes at `arr_addr_o` = {sector, offset}, with offsets ascending, one every PROG_CYC cycles. One `arr_erase_o` strobe then follows PROG_CYC cycles after the last write. The next sector's first write follows ERASE_CYC cycles after the erase strobe.
- R5: Sectors whose `protect_i` bit is 1 when the block launches get no strobes. If no unprotected sector is selected, the block returns to idle with no array activity.
- R6: A chip-erase strobe while idle starts execution at once, with `window_o` staying low and `busy_o` high in the next cycle, over every unprotected sector.
- R7: While `busy_o` is high, add, chip-erase and other-command strobes are ignored. The strobe sequence and its timing stay unchanged.
- R8: A suspend strobe while busy raises `suspended_o` in the next cycle. While it is high, no array strobe is issued and the position is frozen. After a resume strobe, every location and sector is still strobed exactly once.
- R9: `rd_ok_o` is 1 when not busy. While busy it is 1 only if the block is suspended and sector `rd_sector_i` is not pending (current or still queued).
- R10: `busy_o` is high from the cycle after launch until ERASE_CYC cycles after the last erase strobe. It is never high at the same time as `window_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_sector_i | input | 1 | Strobe: add a sector to the erase set |
| add_sel_i | input | 3 | Sector number for `add_sector_i` |
| chip_erase_i | input | 1 | Strobe: erase every sector |
| suspend_i | input | 1 | Strobe: pause a running erase |
| resume_i | input | 1 | Strobe: continue a paused erase |
| other_cmd_i | input | 1 | Strobe: any other decoded command |
| protect_i | input | 8 | Per-sector protection, bit n for sector n |
| rd_sector_i | input | 3 | Sector the read path wants to access |
| arr_prog_o | output | 1 | Write zero to `arr_addr_o` this cycle |
| arr_erase_o | output | 1 | Erase sector `arr_sector_o` this cycle |
| arr_addr_o | output | 3+OFS_W | {sector, offset} for the zero write |
| arr_sector_o | output | 3 | Sector being worked on |
| busy_o | output | 1 | Erase execution in progress |
| window_o | output | 1 | Acceptance window open |
| suspended_o | output | 1 | Execution paused |
| rd_ok_o | output | 1 | Reads of `rd_sector_i` return array data |

## Verification
A stale or corrupted selection mask shows at the array port as a missing, extra or out-of-order sector. It appears within one sector span (2^OFS_W·PROG_CYC + ERASE_CYC cycles) of the point where the bad sector should have been visited. A window counter that is off by one moves the first write strobe by a cycle relative to the fall of `window_o`, which is visible right at launch. A suspend that fails to freeze the position duplicates or skips a zero-write address, and the strobe log shows this after resume. Sweeping every non-empty mask against a varying protection pattern exposes any fault in the skip and ordering logic.

// File: rtl/esch_pkg.sv
package esch_pkg;
  localparam int SECT_N = 8;
  localparam int SECT_W = 3;

  typedef enum logic [1:0] {PH_OFF, PH_PREP, PH_ERASE} phase_e;

  // one-hot selection bit for a sector number
  function automatic logic [SECT_N-1:0] sect_bit(input logic [SECT_W-1:0] s);
    return SECT_N'(1) << s;
  endfunction

  // cycles spent on one sector: zero-fill of every offset, then the erase pulse
  function automatic int unsigned sector_span(input int unsigned n_off,
                                              input int unsigned prog_cyc,
                                              input int unsigned erase_cyc);
    return n_off * prog_cyc + erase_cyc;
  endfunction
endpackage

// File: rtl/esch_pick.sv
// Lowest set bit of a mask, as an index plus a valid flag.
module esch_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] mask_i,
  output logic [W-1:0] idx_o,
  output logic         valid_o
);
  logic [N:0]   below;
  logic [N-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign first[i]   = mask_i[i] & ~below[i];
    assign below[i+1] = below[i] | mask_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) idx_o = idx_o | W'(i);
  end

  assign valid_o = below[N];
endmodule

// File: rtl/esch_win_timer.sv
// Retriggerable acceptance window counted in clock cycles.
module esch_win_timer #(
  parameter int WIN_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  output logic open_o,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      cnt_q  <= RELOAD;
    end else if (open_q) begin
      if (cnt_q == '0) open_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign open_o   = open_q;
  assign expire_o = open_q && (cnt_q == '0) && !load_i && !clear_i;

  AST_WIN_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    open_q && !load_i && !clear_i && cnt_q != '0 |=> open_q && cnt_q == $past(cnt_q) - 1'b1); // R1
  AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !clear_i |=> open_q && cnt_q == RELOAD); // R2
  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !open_q); // R3
endmodule

// File: rtl/esch_seq.sv
// Per-sector sequencer: zero-write every offset, then one erase pulse.
module esch_seq import esch_pkg::*; #(
  parameter int OFS_W     = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hold_i,
  output logic             prog_o,
  output logic             erase_o,
  output logic [OFS_W-1:0] off_o,
  output logic             done_o,
  output logic             active_o
);
  localparam int TMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PROG_LAST  = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_CYC - 1);

  phase_e           ph_q;
  logic [TW-1:0]    tick_q;
  logic [OFS_W-1:0] off_q;
  logic             run;

  assign run = (ph_q != PH_OFF) && !hold_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      tick_q <= '0;
      off_q  <= '0;
    end else if (start_i) begin
      ph_q   <= PH_PREP;
      tick_q <= '0;
      off_q  <= '0;
    end else if (run) begin
      if (ph_q == PH_PREP) begin
        if (tick_q == PROG_LAST) begin
          tick_q <= '0;
          if (&off_q) ph_q  <= PH_ERASE;
          else        off_q <= off_q + 1'b1;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end else begin
        if (tick_q == ERASE_LAST) begin
          ph_q   <= PH_OFF;
          tick_q <= '0;
          off_q  <= '0;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  assign prog_o   = run && (ph_q == PH_PREP)  && (tick_q == '0);
  assign erase_o  = run && (ph_q == PH_ERASE) && (tick_q == '0);
  assign done_o   = run && (ph_q == PH_ERASE) && (tick_q == ERASE_LAST);
  assign active_o = (ph_q != PH_OFF);
  assign off_o    = off_q;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_o && erase_o)); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i && !start_i |=> off_q == $past(off_q) && tick_q == $past(tick_q)); // R8
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o && !start_i |=> off_q == $past(off_q) || off_q == $past(off_q) + 1'b1); // R4
endmodule

// File: rtl/erase_sched.sv
module erase_sched import esch_pkg::*; #(
  parameter int OFS_W     = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 50000,
  parameter int WIN_CYC   = 4000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_sector_i,
  input  logic [SECT_W-1:0]       add_sel_i,
  input  logic                    chip_erase_i,
  input  logic                    suspend_i,
  input  logic                    resume_i,
  input  logic                    other_cmd_i,
  input  logic [SECT_N-1:0]       protect_i,
  input  logic [SECT_W-1:0]       rd_sector_i,
  output logic                    arr_prog_o,
  output logic                    arr_erase_o,
  output logic [SECT_W+OFS_W-1:0] arr_addr_o,
  output logic [SECT_W-1:0]       arr_sector_o,
  output logic                    busy_o,
  output logic                    window_o,
  output logic                    suspended_o,
  output logic                    rd_ok_o
);
  logic              win_open, win_expire;
  logic              seq_active, seq_done, seq_prog, seq_erase;
  logic [OFS_W-1:0]  seq_off;
  logic [SECT_N-1:0] mask_q, cand;
  logic [SECT_W-1:0] cur_q, pick_idx;
  logic              pick_valid;
  logic              susp_q;
  logic              win_abandon, idle_chip, accept, launch, start;

  // command classification
  assign win_abandon = win_open && (other_cmd_i || chip_erase_i || resume_i);
  assign idle_chip   = chip_erase_i && !win_open && !seq_active;
  assign accept      = add_sector_i && !seq_active && !win_abandon && !idle_chip;
  assign launch      = idle_chip || win_expire || seq_done;

  // candidate set for the next sector
  always_comb begin
    if (idle_chip)       cand = ~protect_i;
    else if (win_expire) cand = mask_q & ~protect_i;
    else if (seq_done)   cand = mask_q & ~sect_bit(cur_q);
    else                 cand = '0;
  end

  assign start = launch && pick_valid;

  esch_pick #(.N(SECT_N), .W(SECT_W)) i_pick (
    .mask_i  (cand),
    .idx_o   (pick_idx),
    .valid_o (pick_valid)
  );

  esch_win_timer #(.WIN_CYC(WIN_CYC)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .clear_i  (win_abandon),
    .open_o   (win_open),
    .expire_o (win_expire)
  );

  esch_seq #(.OFS_W(OFS_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .hold_i   (susp_q),
    .prog_o   (seq_prog),
    .erase_o  (seq_erase),
    .off_o    (seq_off),
    .done_o   (seq_done),
    .active_o (seq_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cur_q  <= '0;
    end else begin
      if (win_abandon)  mask_q <= '0;
      else if (accept)  mask_q <= (win_open ? mask_q : '0) | sect_bit(add_sel_i);
      else if (launch)  mask_q <= cand;
      if (start) cur_q <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          susp_q <= 1'b0;
    else if (!seq_active) susp_q <= 1'b0;
    else if (suspend_i)  susp_q <= 1'b1;
    else if (resume_i)   susp_q <= 1'b0;
  end

  assign arr_prog_o   = seq_prog;
  assign arr_erase_o  = seq_erase;
  assign arr_addr_o   = {cur_q, seq_off};
  assign arr_sector_o = cur_q;
  assign busy_o       = seq_active;
  assign window_o     = win_open;
  assign suspended_o  = susp_q;
  assign rd_ok_o      = !seq_active || (susp_q && !mask_q[rd_sector_i]);

  AST_WIN_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(window_o && busy_o)); // R10
  AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    win_abandon |=> !window_o && mask_q == '0); // R3
  AST_IGNORE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !seq_done |=> mask_q == $past(mask_q)); // R7
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && start |=> cur_q > $past(cur_q)); // R4
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended_o |-> !arr_prog_o && !arr_erase_o); // R8
  AST_PROT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase_o |-> !protect_i[arr_sector_o]); // R5
  AST_CUR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> mask_q[cur_q]); // R9
endmodule

// File: tb/test_erase_sched.sv
module test_erase_sched;
  localparam int CLK_PER = 10;
  localparam int OFS_W   = 2;
  localparam int NOFF    = 1 << OFS_W;
  localparam int PROG    = 2;
  localparam int ERASE   = 5;
  localparam int WIN     = 6;
  localparam int SPAN    = NOFF * PROG + ERASE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic add_sector = 0, chip_erase = 0, suspend = 0, resume = 0, other_cmd = 0;
  logic [2:0] add_sel = '0, rd_sector = '0;
  logic [7:0] protect = '0;
  logic arr_prog, arr_erase, busy, window, suspended, rd_ok;
  logic [2+OFS_W:0] arr_addr;
  logic [2:0] arr_sector;

  int checks = 0, fails = 0, cyc = 0, fall_t = 0, logn = 0;
  bit wprev = 0;
  bit log_kind [64];
  int log_sec [64];
  int log_off [64];
  int log_t [64];

  always #(CLK_PER/2) clk = ~clk;

  erase_sched #(.OFS_W(OFS_W), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .WIN_CYC(WIN)) i_erase_sched (
    .clk(clk), .rst_n(rst_n), .add_sector_i(add_sector), .add_sel_i(add_sel),
    .chip_erase_i(chip_erase), .suspend_i(suspend), .resume_i(resume),
    .other_cmd_i(other_cmd), .protect_i(protect), .rd_sector_i(rd_sector),
    .arr_prog_o(arr_prog), .arr_erase_o(arr_erase), .arr_addr_o(arr_addr),
    .arr_sector_o(arr_sector), .busy_o(busy), .window_o(window),
    .suspended_o(suspended), .rd_ok_o(rd_ok));

  // strobe monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (wprev && !window) fall_t = cyc;
    wprev = window;
    if ((arr_prog || arr_erase) && logn < 64) begin
      log_kind[logn] = arr_erase;
      log_sec[logn]  = arr_erase ? int'(arr_sector) : int'(arr_addr[2+OFS_W:OFS_W]);
      log_off[logn]  = arr_erase ? 0 : int'(arr_addr[OFS_W-1:0]);
      log_t[logn]    = cyc;
      logn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic add_set(input logic [7:0] m);
    for (int s = 7; s >= 0; s--)
      if (m[s]) begin
        add_sector = 1; add_sel = 3'(s);
        @(negedge clk);
      end
    add_sector = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((window || busy) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    cycles(2);
  endtask

  task automatic wait_busy();
    int guard = 0;
    while (!busy && guard < 200) begin
      @(negedge clk); guard++;
    end
  endtask

  // expected strobe list from the mask: ascending sectors, offsets, then erase
  task automatic compare_log(input logic [7:0] eff, input bit timed, input string req);
    int n_exp = $countones(eff) * (NOFF + 1);
    int k = 0, si = 0, bad_at = -1;
    int exp_t;
    for (int s = 0; s < 8; s++) begin
      if (eff[s]) begin
        for (int o = 0; o <= NOFF; o++) begin
          exp_t = si * SPAN + o * PROG;
          if (bad_at < 0 && k < logn)
            if (log_kind[k] != (o == NOFF) || log_sec[k] != s ||
                (o < NOFF && log_off[k] != o) ||
                (timed && (log_t[k] - log_t[0]) != exp_t))
              bad_at = k;
          k++;
        end
        si++;
      end
    end
    checks++;
    if (bad_at >= 0 || logn != n_exp) begin
      fails++;
      if (bad_at >= 0)
        $display("FAIL %s: mask %02h event %0d actual sec %0d off %0d erase %0d t+%0d",
                 req, eff, bad_at, log_sec[bad_at], log_off[bad_at],
                 log_kind[bad_at], log_t[bad_at] - log_t[0]);
      else
        $display("FAIL %s: mask %02h actual %0d events expected %0d", req, eff, logn, n_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int n0;
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(!busy && !window, "R10 reset flags", {busy, window}, 0);
    chk(!suspended, "R8 reset suspended", suspended, 0);
    chk(rd_ok, "R9 reset rd_ok", rd_ok, 1);
    chk(!arr_prog && !arr_erase, "R4 reset strobes", {arr_prog, arr_erase}, 0);

    // R1: window length, single sector; R4 timing from window fall
    logn = 0;
    add_sector = 1; add_sel = 3;
    @(negedge clk); add_sector = 0;
    n = 0;
    while (window) begin n++; @(negedge clk); end
    chk(n == WIN, "R1 window length", n, WIN);
    chk(busy, "R10 busy after launch", busy, 1);
    drain();
    chk(logn > 0 && log_t[0] == fall_t, "R4 first write after window fall", log_t[0], fall_t);
    compare_log(8'h08, 1, "R1 R4 single sector");
    chk(!busy, "R10 busy cleared", busy, 0);

    // R2: retrigger at fourth open cycle
    logn = 0;
    add_sector = 1; add_sel = 3;
    @(negedge clk); add_sector = 0;
    n = 0;
    while (window && n < 100) begin
      n++;
      if (n == 4) begin add_sector = 1; add_sel = 5; end
      else add_sector = 0;
      @(negedge clk);
    end
    add_sector = 0;
    chk(n == 4 + WIN, "R2 retriggered window", n, 4 + WIN);
    drain();
    compare_log(8'h28, 1, "R2 two sectors");

    // R3: abandon by other, chip, resume
    for (int kind = 0; kind < 3; kind++) begin
      logn = 0;
      add_sector = 1; add_sel = 2;
      @(negedge clk); add_sector = 0;
      other_cmd = (kind == 0); chip_erase = (kind == 1); resume = (kind == 2);
      @(negedge clk);
      other_cmd = 0; chip_erase = 0; resume = 0;
      chk(!window && !busy, "R3 abandon closes window", {window, busy}, 0);
      cycles(15);
      chk(logn == 0, "R3 abandon no array activity", logn, 0);
    end

    // R3: suspend inside window ignored
    logn = 0;
    add_sector = 1; add_sel = 1;
    @(negedge clk); add_sector = 0; suspend = 1;
    n = 0;
    while (window && n < 100) begin n++; @(negedge clk); suspend = 0; end
    suspend = 0;
    chk(n == WIN, "R3 suspend in window ignored", n, WIN);
    drain();
    compare_log(8'h02, 1, "R3 erase after ignored suspend");

    // R6: chip erase with protection
    logn = 0; protect = 8'h24;
    chip_erase = 1;
    @(negedge clk); chip_erase = 0;
    chk(!window && busy, "R6 chip erase immediate", {window, busy}, 1);
    drain();
    compare_log(8'hDB, 1, "R6 R5 chip erase");

    // R5: everything protected
    logn = 0; protect = 8'hFF;
    chip_erase = 1;
    @(negedge clk); chip_erase = 0;
    chk(!busy && !window, "R5 nothing to erase stays idle", busy, 0);
    cycles(10);
    chk(logn == 0, "R5 no array activity", logn, 0);
    protect = 8'h00;

    // R7: commands during execution are ignored
    logn = 0;
    add_set(8'h11);
    wait_busy();
    cycles(3);
    add_sector = 1; add_sel = 2; @(negedge clk); add_sector = 0;
    chip_erase = 1; @(negedge clk); chip_erase = 0;
    other_cmd = 1; @(negedge clk); other_cmd = 0;
    drain();
    compare_log(8'h11, 1, "R7 ignored during execution");

    // R8 R9: suspend / resume
    logn = 0;
    add_set(8'h06);
    wait_busy();
    cycles(3);
    rd_sector = 5; #1;
    chk(!rd_ok, "R9 read blocked while running", rd_ok, 0);
    suspend = 1; @(negedge clk); suspend = 0;
    chk(suspended, "R8 suspended flag", suspended, 1);
    n0 = logn;
    cycles(20);
    chk(logn == n0, "R8 no strobes while suspended", logn, n0);
    rd_sector = 5; #1;
    chk(rd_ok, "R9 read other sector while suspended", rd_ok, 1);
    rd_sector = 1; #1;
    chk(!rd_ok, "R9 read current sector blocked", rd_ok, 0);
    rd_sector = 2; #1;
    chk(!rd_ok, "R9 read queued sector blocked", rd_ok, 0);
    @(negedge clk);
    resume = 1; @(negedge clk); resume = 0;
    chk(!suspended, "R8 resume clears flag", suspended, 0);
    drain();
    compare_log(8'h06, 0, "R8 each location once after resume");
    rd_sector = 2; #1;
    chk(rd_ok, "R9 read ok when idle", rd_ok, 1);

    // R4 R5 sweep over every non-empty mask with varying protection
    for (int m = 1; m < 256; m++) begin
      logic [7:0] mm = 8'(m);
      logic [7:0] pp = mm[0] ? 8'h00 : (8'(m * 29) ^ 8'hC5);
      @(negedge clk);
      logn = 0; protect = pp;
      add_set(mm);
      drain();
      compare_log(mm & ~pp, 1, "R4 R5 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule